// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

This peripheral holds two independent 32-bit counters that step down by one on every system clock while enabled. Each counter has a reload register and a live count register, and a shared control register carries a run bit and an auto-reload bit for each counter. With auto-reload set, a counter that reaches zero restarts from its reload value, which gives periodic ticks or, with an all-ones reload, a free-running count. With auto-reload clear, the counter stops at zero and drops its own run bit, which gives a one-shot delay.

Every expiry is latched into an event register that software clears explicitly, and an enable register gates each latched event onto its own interrupt line. Access is through a single-cycle register port: a write takes effect on the clock edge where `wr_en` is high, and `rdata` presents the register selected by `addr`, registered, one clock later.

Top module: `twin_countdown_timer`

## Requirements
- R1: After synchronous reset, all counts, reload values, control, event and enable bits are zero, `irq` is 0 and `rdata` is 0.
- R2: The control register sits at offset 0x00: bit 0 runs counter 0, bit 1 sets auto-reload for counter 0, bit 2 runs counter 1, bit 3 sets auto-reload for counter 1; it reads back in bits 3:0 with upper bits zero.
- R3: Counter 0 has its reload register at 0x10 and its count at 0x14; counter 1 has reload at 0x18 and count at 0x1C; `rdata` shows the register addressed in the previous cycle, and reading a count gives its live value.
- R4: A running counter with a nonzero count decreases by exactly one per clock; a counter whose run bit is clear holds its value.
- R5: A write to a count register loads it directly and overrides the decrement and the reload of that cycle, and no expiry happens in that cycle.
- R6: A running counter at zero with auto-reload set takes its reload value on the next clock, so a reload of N-1 gives an expiry every N clocks.
- R7: A running counter at zero with auto-reload clear stays at zero and its run bit clears on that clock, unless the control register is written in the same cycle.
- R8: With reload 0xFFFFFFFF and auto-reload set, a counter at zero wraps to 0xFFFFFFFF and keeps counting down.
- R9: The event register is at 0x20 and the enable register at 0x24; counter 0 uses bit 1 and counter 1 uses bit 2 of both; an expiry sets its event bit whatever its enable bit, and `irq[i]` is high exactly when counter i's event and enable bits are both set.
- R10: Event bits are cleared by writing 0 and kept by writing 1; an expiry in the same cycle as a clear leaves the bit set; an event-register write leaves the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; counters step on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Register byte offset for read and write |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for last cycle's address |
| irq | output | 2 | Per-counter interrupt, event AND enable |

## Verification
The assertions assume the register port is driven with a stable address and strobe for a full clock and that only one register is written per cycle, which the single-port interface guarantees; the stimulus changes inputs only on the falling edge. Counter checks assume the run bit and the write strobe are sampled on the same edge as the count, so the bench places its control writes, count writes and event clears at chosen offsets from an expiry to land a write on the very cycle a counter hits zero. A behavioural model in the bench tracks both counters, the control, event and enable bits and is compared against `rdata` and `irq` every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned N_TMR   = 2;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned OFF_CTL   = 'h00;
  localparam int unsigned OFF_RL0   = 'h10;
  localparam int unsigned OFF_CNT0  = 'h14;
  localparam int unsigned OFF_STEP  = 'h08;
  localparam int unsigned OFF_EVT   = 'h20;
  localparam int unsigned OFF_ENA   = 'h24;
  localparam int unsigned EVT_LSB   = 1;
  localparam int unsigned CTL_BITS  = 2 * N_TMR;

  function automatic int unsigned rl_off(input int unsigned idx);
    return OFF_RL0 + idx * OFF_STEP;
  endfunction

  function automatic int unsigned cnt_off(input int unsigned idx);
    return OFF_CNT0 + idx * OFF_STEP;
  endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         autoload,
  input  logic         load_cnt,
  input  logic         load_rl,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rl,
  output logic         expire
);
  logic at_zero;
  assign at_zero = (cnt == '0);
  assign expire  = run && at_zero && !load_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      rl  <= '0;
    end else begin
      if (load_rl) rl <= wdata;
      if (load_cnt) begin
        cnt <= wdata;
      end else if (run) begin
        if (at_zero) begin
          if (autoload) cnt <= rl;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !at_zero && !load_cnt) |=> (cnt == $past(cnt) - 1'b1));
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_cnt) |=> $stable(cnt));
  assert_load_wins_R5: assert property (@(posedge clk) disable iff (rst)
    load_cnt |=> (cnt == $past(wdata)));
  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (run && at_zero && autoload && !load_cnt) |=> (cnt == $past(rl)));
  assert_oneshot_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (run && at_zero && !autoload && !load_cnt) |=> (cnt == '0));
endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         wr_evt,
  input  logic         wr_ena,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] pend,
  output logic [N-1:0] ena,
  output logic [N-1:0] irq
);
  logic [N-1:0] keep;
  assign keep = wr_evt ? wbits : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      ena  <= '0;
    end else begin
      pend <= (pend & keep) | evt;
      if (wr_ena) ena <= wbits;
    end
  end

  assign irq = pend & ena;

  assert_event_latched_R9: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));
  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && evt == '0) |=> (pend == ($past(pend) & $past(wbits))));
  assert_ena_untouched_R10: assert property (@(posedge clk) disable iff (rst)
    (!wr_ena) |=> $stable(ena));
  assert_pend_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (!wr_evt) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: rtl/twin_countdown_timer.sv
module twin_countdown_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_TMR-1:0]  irq
);
  logic [CTL_BITS-1:0] ctl;
  logic [N_TMR-1:0]    expire;
  logic [N_TMR-1:0]    pend, ena;
  logic [DATA_W-1:0]   cnt [N_TMR];
  logic [DATA_W-1:0]   rlv [N_TMR];
  logic                wr_ctl, wr_evt, wr_ena;

  assign wr_ctl = wr_en && (addr == ADDR_W'(OFF_CTL));
  assign wr_evt = wr_en && (addr == ADDR_W'(OFF_EVT));
  assign wr_ena = wr_en && (addr == ADDR_W'(OFF_ENA));

  for (genvar i = 0; i < N_TMR; i++) begin : g_ch
    logic ld_cnt, ld_rl;
    assign ld_cnt = wr_en && (addr == ADDR_W'(cnt_off(i)));
    assign ld_rl  = wr_en && (addr == ADDR_W'(rl_off(i)));
    tmr_channel #(.W(DATA_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .run      (ctl[2*i]),
      .autoload (ctl[2*i+1]),
      .load_cnt (ld_cnt),
      .load_rl  (ld_rl),
      .wdata    (wdata),
      .cnt      (cnt[i]),
      .rl       (rlv[i]),
      .expire   (expire[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (wr_ctl) begin
      ctl <= wdata[CTL_BITS-1:0];
    end else begin
      for (int i = 0; i < N_TMR; i++) begin
        if (expire[i] && !ctl[2*i+1]) ctl[2*i] <= 1'b0;
      end
    end
  end

  tmr_irq_latch #(.N(N_TMR)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .evt    (expire),
    .wr_evt (wr_evt),
    .wr_ena (wr_ena),
    .wbits  (wdata[EVT_LSB +: N_TMR]),
    .pend   (pend),
    .ena    (ena),
    .irq    (irq)
  );

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(OFF_CTL)) rd_next[CTL_BITS-1:0] = ctl;
    if (addr == ADDR_W'(OFF_EVT)) rd_next[EVT_LSB +: N_TMR] = pend;
    if (addr == ADDR_W'(OFF_ENA)) rd_next[EVT_LSB +: N_TMR] = ena;
    for (int i = 0; i < N_TMR; i++) begin
      if (addr == ADDR_W'(rl_off(i)))  rd_next = rlv[i];
      if (addr == ADDR_W'(cnt_off(i))) rd_next = cnt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assert_oneshot_stops_R7: assert property (@(posedge clk) disable iff (rst)
    (expire[0] && !ctl[1] && !wr_ctl) |=> !ctl[0]);
  assert_oneshot_stops1_R7: assert property (@(posedge clk) disable iff (rst)
    (expire[1] && !ctl[3] && !wr_ctl) |=> !ctl[2]);
  assert_autoload_keeps_run_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl[0] && ctl[1] && !wr_ctl) |=> (ctl[1:0] == 2'b11));
  assert_ctl_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> (ctl == $past(wdata[CTL_BITS-1:0])));
endmodule

// File: tb/sim_twin_countdown_timer.sv
module sim_twin_countdown_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  twin_countdown_timer u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;
  string tag = "R1";

  // behavioural reference state
  logic [31:0] m_cnt [2];
  logic [31:0] m_rl  [2];
  logic [3:0]  m_ctl;
  logic [1:0]  m_evt, m_ena;
  logic [31:0] m_rd;

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_rl[i] = 0; end
    m_ctl = 0; m_evt = 0; m_ena = 0; m_rd = 0;
  endtask

  task automatic model_edge();
    logic [31:0] n_cnt [2];
    logic [1:0]  fired;
    int a;
    a = addr;
    fired = 0;
    // read data from pre-edge state
    case (a)
      'h00: m_rd = {28'd0, m_ctl};
      'h10: m_rd = m_rl[0];
      'h14: m_rd = m_cnt[0];
      'h18: m_rd = m_rl[1];
      'h1C: m_rd = m_cnt[1];
      'h20: m_rd = {29'd0, m_evt, 1'b0};
      'h24: m_rd = {29'd0, m_ena, 1'b0};
      default: m_rd = 0;
    endcase
    for (int i = 0; i < 2; i++) begin
      n_cnt[i] = m_cnt[i];
      if (wr_en && a == 'h14 + 8*i) n_cnt[i] = wdata;
      else if (m_ctl[2*i]) begin
        if (m_cnt[i] == 0) begin
          fired[i] = 1;
          if (m_ctl[2*i+1]) n_cnt[i] = m_rl[i];
        end else n_cnt[i] = m_cnt[i] - 1;
      end
    end
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = n_cnt[i];
      if (wr_en && a == 'h10 + 8*i) m_rl[i] = wdata;
    end
    if (wr_en && a == 'h00) m_ctl = wdata[3:0];
    else for (int i = 0; i < 2; i++)
      if (fired[i] && !m_ctl[2*i+1]) m_ctl[2*i] = 0;
    if (wr_en && a == 'h20) m_evt = m_evt & wdata[2:1];
    m_evt = m_evt | fired;
    if (wr_en && a == 'h24) m_ena = wdata[2:1];
  endtask

  task automatic compare();
    checks++;
    if (rdata !== m_rd) begin
      errors++;
      $display("FAIL %s rdata actual %h expected %h (t=%0t)", tag, rdata, m_rd, $time);
    end
    checks++;
    if (irq !== (m_evt & m_ena)) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b (t=%0t)", tag, irq, m_evt & m_ena, $time);
    end
  endtask

  // one clock: edge, model update, compare on falling edge
  task automatic step();
    @(posedge clk);
    if (rst) model_reset(); else model_edge();
    @(negedge clk);
    compare();
    cycles++;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic idle(input logic [5:0] a, input int n);
    addr = a; wr_en = 1'b0;
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    step(); step(); step();
    rst = 1'b0;
    tag = "R1";  idle('h14, 2); idle('h00, 2); idle('h20, 2);
    tag = "R2";  wr('h00, 32'hFFFF_FFF0); idle('h00, 2);
    wr('h00, 32'h0000_0005); idle('h00, 3); wr('h00, 0); idle('h00, 2);
    tag = "R3";  wr('h10, 32'h0000_0004); wr('h14, 32'h0000_000A);
    wr('h18, 32'h1234_5678); wr('h1C, 32'h0000_0030);
    idle('h10, 2); idle('h18, 2); idle('h1C, 2);
    tag = "R4";  wr('h00, 32'h1); idle('h14, 6);
    tag = "R7";  idle('h14, 8); idle('h00, 2); idle('h20, 2);
    tag = "R9";  wr('h24, 32'h2); idle('h24, 2); idle('h20, 2);
    tag = "R10"; wr('h20, 32'h6); idle('h20, 2); idle('h24, 2);
    wr('h20, 32'h0); idle('h20, 2);
    tag = "R6";  wr('h14, 32'h2); wr('h10, 32'h3); wr('h00, 32'h3);
    idle('h14, 20); idle('h20, 1);
    tag = "R5";  wr('h14, 32'h7); idle('h14, 3);
    wr('h14, 32'h0); idle('h14, 2); wr('h14, 32'h0); idle('h14, 3);
    tag = "R4";  wr('h00, 32'h2); idle('h14, 4);
    tag = "R10"; wr('h24, 32'h6); wr('h20, 32'h0);
    wr('h1C, 32'h1); wr('h00, 32'h4); idle('h1C, 1); wr('h20, 32'h0);
    idle('h20, 2); idle('h00, 2);
    tag = "R7";  wr('h1C, 32'h0); wr('h00, 32'h4); wr('h00, 32'h4);
    idle('h00, 3);
    tag = "R8";  wr('h18, 32'hFFFF_FFFF); wr('h1C, 32'h2); wr('h00, 32'hC);
    idle('h1C, 6); idle('h20, 2);
    tag = "R9";  wr('h24, 32'h0); idle('h20, 2); wr('h24, 32'h4); idle('h24, 2);
    tag = "R1";  rst = 1'b1; step(); rst = 1'b0; idle('h1C, 2); idle('h00, 2);
    done = 1;
    summary();
  end

  initial begin
    while (cycles < WATCHDOG && !done) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      summary();
    end
  end
endmodule